// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a high-precision event timer. It watches a free-running 64-bit main count supplied from outside. When that count reaches the channel's comparator, it emits a one-cycle expiry pulse. Software programs the channel through three 32-bit write strobes that share one data bus: a configuration word, the low comparator word and the high comparator word. The configuration, comparator and period registers can be read back at all times.

The channel has two modes. In one-shot mode the comparator stays where software put it. In periodic mode a hidden period register is added to the comparator after each expiry. If the count has run ahead, the addition is repeated until the comparator lies in front of the count again. A narrow mode makes every comparison and every sum work modulo 2^32. In narrow one-shot mode the channel also emits an extra event when the low count word wraps, provided the wrap comes before the match.

A small state machine controls the channel. It has five states: OFF, ARM, WRAP, MATCH and ADVANCE.
- **OFF**: the channel is inactive. It moves to ARM once both the channel enable and the global run input are high.
- **ARM**: the channel evaluates its registers against the count. On a hit it fires and goes to ADVANCE (periodic mode with a nonzero period) or to MATCH. If there is no hit and a wrap comes first, it goes to WRAP. Otherwise it goes to MATCH.
- **WRAP**: the channel waits for the low count word to reach all ones, fires, and then goes to MATCH.
- **MATCH**: the channel fires on equality. In periodic mode with a nonzero period it then adds the period and goes to ADVANCE.
- **ADVANCE**: while the comparator is not ahead of the count, the channel adds the period again. When the comparator is ahead, it returns to MATCH.

From any state, losing either enable leads to OFF. A register write while the channel is active leads to ARM.

Top module: `evt_chan`

## Requirements
- R1: After reset, the comparator reads all ones, the period reads zero, the configuration reads 0x30 and no expiry pulse is present.
- R2: The configuration word has these bits: bit 0 is the channel enable, bit 1 is periodic mode, bit 2 is set-value and bit 3 is narrow mode. These four bits are writable. Bits 4 (periodic capable) and 5 (wide capable) always read 1, and all other bits always read 0, whatever is written.
- R3: In one-shot mode, `fire_o` is high for one cycle, in the cycle after the clock edge at which the count equals the comparator. The comparator keeps its value.
- R4: No expiry pulse is produced unless both the channel enable bit and `run_i` were high at that edge.
- R5: In periodic mode without set-value, a comparator-word write updates only the matching word of the period. The comparator is left unchanged.
- R6: With set-value and periodic mode, a comparator-word write updates both the comparator and the period. Any comparator-word write clears set-value.
- R7: In periodic mode with a nonzero period, each expiry adds the period to the comparator, so events repeat every period ticks.
- R8: If the count is past the comparator after an expiry, the period is added once per cycle until the comparator is ahead of the count. "Ahead" means the signed difference is positive.
- R9: Bit 63 of the period is always cleared. In narrow mode, bit 31 of a period value written through the low word is also cleared.
- R10: A configuration write with the narrow bit set clears the upper 32 bits of both the comparator and the period.
- R11: In narrow mode, high-word writes are ignored.
- R12: In narrow one-shot mode, if the low count word reaches 0xFFFFFFFF before the low comparator word, an extra event fires at that count value. The match event still fires afterwards.
- R13: In narrow mode, matches, ordering and period sums use only the low 32 bits, so the comparator wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_i | input | 64 | Main counter value |
| run_i | input | 1 | Global counter enable |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cmp_lo_we_i | input | 1 | Comparator low word write strobe |
| cmp_hi_we_i | input | 1 | Comparator high word write strobe |
| wdata_i | input | 32 | Write data |
| fire_o | output | 1 | Expiry pulse |
| cfg_o | output | 32 | Configuration readback |
| cmp_o | output | 64 | Comparator readback |
| period_o | output | 64 | Period readback |

## Verification
The hardest case to reach is the narrow one-shot wrap event. It needs the comparator a short distance past the 32-bit wrap point and the count a few ticks below it, with the upper count word nonzero. In a live system that would take billions of ticks. Because the count is a port, the stimulus places the count just under 0xFFFFFFFF, arms the channel there and sweeps across the wrap, expecting two events. The same jump-the-count approach drives the periodic catch-up loop: the count is leapt far past the comparator so that several additions are needed.

// File: rtl/evt_chan_pkg.sv
package evt_chan_pkg;
    localparam int CFG_W = 32;

    localparam int B_EN   = 0;
    localparam int B_PER  = 1;
    localparam int B_SETV = 2;
    localparam int B_NAR  = 3;
    localparam int B_CAPP = 4;
    localparam int B_CAPW = 5;

    localparam logic [CFG_W-1:0] CFG_WMASK = CFG_W'(4'hF);
    localparam logic [CFG_W-1:0] CFG_CAPS  = CFG_W'((1 << B_CAPP) | (1 << B_CAPW));

    typedef enum logic [2:0] {
        ST_OFF,
        ST_ARM,
        ST_WRAP,
        ST_MATCH,
        ST_ADVANCE
    } chan_state_t;
endpackage

// File: rtl/evt_chan_regs.sv
module evt_chan_regs
    import evt_chan_pkg::*;
#(
    parameter int CNT_W = 64,
    localparam int WORD_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              reload,
    input  logic [CNT_W-1:0]  reload_val,
    output logic [CFG_W-1:0]  cfg,
    output logic [CNT_W-1:0]  cmp,
    output logic [CNT_W-1:0]  period
);
    logic [CFG_W-1:0]  cfg_q, cfg_n;
    logic [CNT_W-1:0]  cmp_q, cmp_n, per_q, per_n;
    logic [WORD_W-1:0] wmask;
    logic              wr_h;
    logic              narrow, periodic, setv;

    assign narrow   = cfg_q[B_NAR];
    assign periodic = cfg_q[B_PER];
    assign setv     = cfg_q[B_SETV];

    always_comb begin
        cfg_n = cfg_q;
        cmp_n = cmp_q;
        per_n = per_q;
        wmask = '1;
        wr_h  = 1'b0;
        if (reload) cmp_n = reload_val;
        for (int h = 0; h < 2; h++) begin
            wr_h  = (h == 0) ? lo_we : hi_we;
            wmask = '1;
            if (h == 1 || narrow) wmask[WORD_W-1] = 1'b0;
            if (wr_h && !(narrow && h == 1)) begin
                if (!periodic || setv) cmp_n[h*WORD_W +: WORD_W] = wdata;
                if (periodic) per_n[h*WORD_W +: WORD_W] = wdata & wmask;
            end
        end
        if (lo_we || hi_we) cfg_n[B_SETV] = 1'b0;
        if (cfg_we) begin
            cfg_n = CFG_W'(wdata) & CFG_WMASK;
            if (wdata[B_NAR]) begin
                cmp_n[CNT_W-1:WORD_W] = '0;
                per_n[CNT_W-1:WORD_W] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            cmp_q <= '1;
            per_q <= '0;
        end else begin
            cfg_q <= cfg_n;
            cmp_q <= cmp_n;
            per_q <= per_n;
        end
    end

    assign cfg    = cfg_q | CFG_CAPS;
    assign cmp    = cmp_q;
    assign period = per_q;
endmodule

// File: rtl/evt_chan_arith.sv
module evt_chan_arith #(
    parameter int CNT_W = 64,
    localparam int WORD_W = CNT_W / 2
) (
    input  logic [CNT_W-1:0] cmp,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] count,
    input  logic             narrow,
    output logic             hit,
    output logic             ahead,
    output logic             per_nz,
    output logic             wrap_edge,
    output logic             wrap_need,
    output logic [CNT_W-1:0] sum
);
    logic [CNT_W-1:0]  dw;
    logic [WORD_W-1:0] dn;

    assign dw = cmp - count;
    assign dn = cmp[WORD_W-1:0] - count[WORD_W-1:0];

    assign hit    = narrow ? (dn == '0) : (dw == '0);
    assign ahead  = narrow ? (!dn[WORD_W-1] && dn != '0)
                           : (!dw[CNT_W-1] && dw != '0);
    assign per_nz = narrow ? (period[WORD_W-1:0] != '0) : (period != '0);
    assign sum    = narrow ? {{WORD_W{1'b0}}, cmp[WORD_W-1:0] + period[WORD_W-1:0]}
                           : cmp + period;

    // Wrap point is the low word at all ones; distance to it is the inverted count.
    assign wrap_edge = &count[WORD_W-1:0];
    assign wrap_need = narrow && ahead && ((~count[WORD_W-1:0]) < dn);
endmodule

// File: rtl/evt_chan_fsm.sv
module evt_chan_fsm
    import evt_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic any_wr,
    input  logic periodic,
    input  logic narrow,
    input  logic per_nz,
    input  logic hit,
    input  logic ahead,
    input  logic wrap_need,
    input  logic wrap_edge,
    output logic reload,
    output logic fire
);
    chan_state_t state_q, state_n;
    logic        fire_n, fire_q;
    logic        repeat_mode;

    assign repeat_mode = periodic && per_nz;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            fire_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            fire_q  <= fire_n;
        end
    end

    always_comb begin
        state_n = state_q;
        if (!active) begin
            state_n = ST_OFF;
        end else if (any_wr) begin
            state_n = ST_ARM;
        end else begin
            unique case (state_q)
                ST_OFF:     state_n = ST_ARM;
                ST_ARM: begin
                    if (hit)                                    state_n = repeat_mode ? ST_ADVANCE : ST_MATCH;
                    else if (narrow && !periodic && wrap_need)  state_n = ST_WRAP;
                    else                                        state_n = ST_MATCH;
                end
                ST_WRAP:    if (wrap_edge) state_n = ST_MATCH;
                ST_MATCH:   if (hit && repeat_mode) state_n = ST_ADVANCE;
                ST_ADVANCE: if (ahead) state_n = ST_MATCH;
                default:    state_n = ST_OFF;
            endcase
        end
    end

    always_comb begin
        fire_n = 1'b0;
        reload = 1'b0;
        if (active && !any_wr) begin
            unique case (state_q)
                ST_ARM, ST_MATCH: begin
                    fire_n = hit;
                    reload = hit && repeat_mode;
                end
                ST_WRAP:    fire_n = wrap_edge;
                ST_ADVANCE: begin
                    reload = !ahead;
                    fire_n = hit;
                end
                default: ;
            endcase
        end
    end

    assign fire = fire_q;
endmodule

// File: rtl/evt_chan.sv
module evt_chan
    import evt_chan_pkg::*;
#(
    parameter int CNT_W = 64,
    localparam int WORD_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              run_i,
    input  logic              cfg_we_i,
    input  logic              cmp_lo_we_i,
    input  logic              cmp_hi_we_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic              fire_o,
    output logic [CFG_W-1:0]  cfg_o,
    output logic [CNT_W-1:0]  cmp_o,
    output logic [CNT_W-1:0]  period_o
);
    logic [CFG_W-1:0] cfg;
    logic [CNT_W-1:0] cmp, period, sum;
    logic hit, ahead, per_nz, wrap_edge, wrap_need, reload;

    evt_chan_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we_i), .lo_we(cmp_lo_we_i), .hi_we(cmp_hi_we_i),
        .wdata(wdata_i), .reload(reload), .reload_val(sum),
        .cfg(cfg), .cmp(cmp), .period(period)
    );

    evt_chan_arith #(.CNT_W(CNT_W)) u_arith (
        .cmp(cmp), .period(period), .count(count_i), .narrow(cfg[B_NAR]),
        .hit(hit), .ahead(ahead), .per_nz(per_nz),
        .wrap_edge(wrap_edge), .wrap_need(wrap_need), .sum(sum)
    );

    evt_chan_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .active(cfg[B_EN] && run_i),
        .any_wr(cfg_we_i || cmp_lo_we_i || cmp_hi_we_i),
        .periodic(cfg[B_PER]), .narrow(cfg[B_NAR]), .per_nz(per_nz),
        .hit(hit), .ahead(ahead), .wrap_need(wrap_need), .wrap_edge(wrap_edge),
        .reload(reload), .fire(fire_o)
    );

    assign cfg_o    = cfg;
    assign cmp_o    = cmp;
    assign period_o = period;
endmodule

// File: rtl/evt_chan_chk.sv
module evt_chan_chk
    import evt_chan_pkg::*;
#(
    parameter int CNT_W = 64,
    localparam int WORD_W = CNT_W / 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_i,
    input logic             cfg_we_i,
    input logic             cmp_lo_we_i,
    input logic             cmp_hi_we_i,
    input logic             fire_o,
    input logic [CFG_W-1:0] cfg_o,
    input logic [CNT_W-1:0] cmp_o,
    input logic [CNT_W-1:0] period_o
);
    p_fire_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> $past(cfg_o[B_EN] && run_i));

    p_setval_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmp_lo_we_i || cmp_hi_we_i) && !cfg_we_i) |=> !cfg_o[B_SETV]);

    p_period_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        period_o[CNT_W-1] == 1'b0);

    p_narrow_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_o[B_NAR] |-> (cmp_o[CNT_W-1:WORD_W] == '0 && period_o[CNT_W-1:WORD_W] == '0));

    p_oneshot_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we_i && !cmp_lo_we_i && !cmp_hi_we_i && !cfg_o[B_PER]) |=> $stable(cmp_o));
endmodule

bind evt_chan evt_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_i(run_i),
    .cfg_we_i(cfg_we_i), .cmp_lo_we_i(cmp_lo_we_i), .cmp_hi_we_i(cmp_hi_we_i),
    .fire_o(fire_o), .cfg_o(cfg_o), .cmp_o(cmp_o), .period_o(period_o)
);

// File: tb/sim_evt_chan.sv
module sim_evt_chan;
    localparam logic [31:0] C_EN = 32'h1, C_PER = 32'h2, C_SETV = 32'h4, C_NAR = 32'h8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] count_i = '0;
    logic        run_i = 1'b0;
    logic        cfg_we_i = 1'b0, cmp_lo_we_i = 1'b0, cmp_hi_we_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic        fire_o;
    logic [31:0] cfg_o;
    logic [63:0] cmp_o, period_o;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #10 clk = ~clk;

    evt_chan u0 (
        .clk(clk), .rst_n(rst_n), .count_i(count_i), .run_i(run_i),
        .cfg_we_i(cfg_we_i), .cmp_lo_we_i(cmp_lo_we_i), .cmp_hi_we_i(cmp_hi_we_i),
        .wdata_i(wdata_i), .fire_o(fire_o), .cfg_o(cfg_o), .cmp_o(cmp_o),
        .period_o(period_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int sel, input logic [31:0] d);
        wdata_i     = d;
        cfg_we_i    = (sel == 0);
        cmp_lo_we_i = (sel == 1);
        cmp_hi_we_i = (sel == 2);
        tick();
        cfg_we_i = 0; cmp_lo_we_i = 0; cmp_hi_we_i = 0;
    endtask

    task automatic step(input logic [63:0] c, output logic f);
        count_i = c;
        tick();
        f = fire_o;
    endtask

    task automatic sweep(input logic [63:0] lo, input logic [63:0] hi,
                         output int nf, output logic [63:0] first, output logic [63:0] last);
        logic f;
        nf = 0; first = '1; last = '1;
        for (logic [63:0] c = lo; c <= hi; c++) begin
            step(c, f);
            if (f) begin
                if (nf == 0) first = c;
                last = c;
                nf++;
            end
        end
    endtask

    function automatic int fires_upto(input int f0, input int p, input int lim);
        int n = 0;
        for (int v = f0; v <= lim; v += p) n++;
        return n;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic f;
        int nf, fz;
        logic [63:0] fa, fb;
        void'($urandom(32'd2024));
        repeat (3) tick();
        // R1 reset values
        check("R1 cfg", 64'(cfg_o), 64'h30);
        check("R1 cmp", cmp_o, '1);
        check("R1 period", period_o, 64'h0);
        check("R1 fire", 64'(fire_o), 64'h0);
        rst_n = 1'b1;
        tick();

        // R2 write mask and capability bits
        wr(0, 32'hFFFF_FFF0);
        check("R2 cfg ro bits", 64'(cfg_o), 64'h30);
        wr(0, 32'h0);

        // R3 one-shot
        wr(1, 32'd100); wr(2, 32'd0);
        check("R3 cmp written", cmp_o, 64'd100);
        run_i = 1; count_i = 64'd50;
        wr(0, C_EN);
        step(64'd50, f); step(64'd50, f);
        sweep(64'd51, 64'd120, nf, fa, fb);
        check("R3 one-shot count", 64'(nf), 64'd1);
        check("R3 one-shot time", fa, 64'd100);
        check("R3 cmp kept", cmp_o, 64'd100);

        // R4 enables gate expiry
        run_i = 0;
        step(64'd90, f); step(64'd100, f); fz = int'(f); step(64'd100, f); fz += int'(f);
        check("R4 run low", 64'(fz), 64'd0);
        run_i = 1;
        step(64'd90, f); step(64'd90, f); step(64'd100, f);
        check("R4 run restored", 64'(f), 64'd1);
        count_i = 64'd90;
        wr(0, 32'h0);
        step(64'd100, f); fz = int'(f); step(64'd100, f); fz += int'(f);
        check("R4 channel off", 64'(fz), 64'd0);

        // R5 R6 R7 periodic with set-value
        wr(0, C_PER | C_SETV);
        check("R6 setval set", 64'(cfg_o), 64'h36);
        wr(1, 32'd40);
        check("R6 cmp", cmp_o, 64'd40);
        check("R6 period", period_o, 64'd40);
        check("R6 setval cleared", 64'(cfg_o), 64'h32);
        count_i = 64'd0;
        wr(0, C_PER | C_EN);
        step(64'd0, f); step(64'd0, f);
        sweep(64'd1, 64'd130, nf, fa, fb);
        check("R7 periodic count", 64'(nf), 64'd3);
        check("R7 last fire", fb, 64'd120);
        check("R7 cmp reloaded", cmp_o, 64'd160);
        wr(1, 32'd25);
        check("R5 period only", period_o, 64'd25);
        check("R5 cmp untouched", cmp_o, 64'd160);

        // R8 catch-up
        step(64'd131, f);
        step(64'd160, f);
        check("R8 fire at cmp", 64'(f), 64'd1);
        fz = 0;
        for (int i = 0; i < 8; i++) begin step(64'd300, f); fz += int'(f); end
        check("R8 no extra fires", 64'(fz), 64'd0);
        check("R8 cmp ahead", cmp_o, 64'd310);
        wr(0, 32'h0);

        // R9 period top bit
        wr(0, C_PER);
        wr(2, 32'hFFFF_FFFF); wr(1, 32'hFFFF_FFFF);
        check("R9 wide period mask", period_o, 64'h7FFF_FFFF_FFFF_FFFF);
        check("R5 cmp kept wide", cmp_o, 64'd310);

        // R10 narrow truncation
        wr(0, 32'h0);
        wr(1, 32'd5); wr(2, 32'd1);
        check("R10 cmp before", cmp_o, 64'h1_0000_0005);
        wr(0, C_NAR);
        check("R10 cmp truncated", cmp_o, 64'h5);
        check("R10 period truncated", period_o, 64'hFFFF_FFFF);
        // R11 high word ignored
        wr(2, 32'd7);
        check("R11 cmp", cmp_o, 64'h5);
        check("R11 period", period_o, 64'hFFFF_FFFF);
        wr(0, C_NAR | C_PER);
        wr(1, 32'hFFFF_FFFF);
        check("R9 narrow period mask", period_o, 64'h7FFF_FFFF);
        check("R9 narrow cmp kept", cmp_o, 64'h5);

        // R12 narrow one-shot wrap event
        wr(0, C_NAR);
        wr(1, 32'h10);
        count_i = 64'h5_FFFF_FFF0;
        wr(0, C_NAR | C_EN);
        step(64'h5_FFFF_FFF0, f); step(64'h5_FFFF_FFF0, f);
        sweep(64'h5_FFFF_FFF1, 64'h6_0000_0020, nf, fa, fb);
        check("R12 event count", 64'(nf), 64'd2);
        check("R12 wrap event", fa, 64'h5_FFFF_FFFF);
        check("R12 match event", fb, 64'h6_0000_0010);

        // R13 narrow periodic modulo
        wr(0, C_NAR | C_PER | C_SETV);
        wr(1, 32'hFFFF_FFF0);
        check("R13 cmp set", cmp_o, 64'hFFFF_FFF0);
        wr(1, 32'h20);
        check("R13 period", period_o, 64'h20);
        count_i = 64'h2_FFFF_FFE0;
        wr(0, C_NAR | C_PER | C_EN);
        step(64'h2_FFFF_FFE0, f); step(64'h2_FFFF_FFE0, f);
        sweep(64'h2_FFFF_FFE1, 64'h3_0000_0010, nf, fa, fb);
        check("R13 event count", 64'(nf), 64'd2);
        check("R13 first", fa, 64'h2_FFFF_FFF0);
        check("R13 second", fb, 64'h3_0000_0010);
        check("R13 cmp wrapped", cmp_o, 64'h30);
        wr(0, 32'h0);

        // R7 random periods
        for (int t = 0; t < 6; t++) begin
            int f0, p, nxt, bad, seen;
            f0 = int'($urandom_range(60, 10));
            p  = int'($urandom_range(40, 3));
            wr(0, C_PER | C_SETV);
            wr(1, 32'(f0));
            wr(1, 32'(p));
            count_i = 64'd0;
            wr(0, C_PER | C_EN);
            step(64'd0, f); step(64'd0, f);
            nxt = f0; bad = 0; seen = 0;
            for (int c = 1; c <= 300; c++) begin
                logic e;
                step(64'(c), f);
                e = (c == nxt);
                if (e) nxt += p;
                if (f !== e) bad++;
                seen += int'(f);
            end
            check("R7 random pattern", 64'(bad), 64'd0);
            check("R7 random count", 64'(seen), 64'(fires_upto(f0, p, 300)));
            count_i = 64'd0;
            wr(0, 32'h0);
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule